// File: doc/BRIEF.md
# Two-Way Data Cache Tag Controller

This block keeps the tag-side state of a small two-way set-associative data cache that uses a copy-back write policy. Each set has two ways. Each way holds a valid flag, a dirty flag, a shared flag and an address tag. Each set also has one replacement bit that names the way to evict next. The lookup runs combinationally from the request index and tag. It reports a hit and the way that hit, or on a miss it names the way to fill. If that way holds dirty data, it also raises a write-back request that carries the outgoing tag. All state changes take effect on the clock edge of a valid request.

The configuration inputs set an enable and a lock mode. The lock can cover both ways or only way 0. A locked way that is still invalid can be filled, which lets critical data be preloaded and pinned. An invalidate strobe clears every valid flag in one cycle. The strobe is refused while a lock is active and the cache is enabled. Multi-word block-move loads that miss never allocate, so a register-stack refill does not push out useful lines. The data array, snooping and the write-back buffer sit outside this block.

Top module: `dcache_tag_ctrl`

## Requirements
- R1: After reset every entry is invalid, so the first lookup to any set misses and, with no lock, fills way 0.
- R2: With the cache enabled, a valid request whose tag matches a valid way of the addressed set reports hit=1 with hitWay set to that way. With reqValid low, hit, alloc and wbReq are all 0.
- R3: While cfgEnable is 0, every lookup reports hit=0 and alloc=0, and no entry changes.
- R4: With cfgLock=2'b00, a miss fills way 0 if it is invalid, else way 1 if it is invalid, else the way named by the set's replacement bit. Every hit or fill sets that bit to the way not just used. A fill makes the next lookup of the same address hit in the filled way.
- R5: A write hit marks the entry dirty. A fill on a write enters dirty, and a fill on a read enters clean. hitModified shows the dirty flag of the hit way.
- R6: When a fill replaces a valid dirty way, wbReq=1 in the same cycle as alloc=1, and wbTag gives the evicted tag. Otherwise wbReq=0 and wbTag=0.
- R7: A fill on a write with reqShared=1 marks the entry shared, and any other fill marks it clean of sharing. hitShared shows the shared flag of the hit way.
- R8: With cfgLock=2'b01 or 2'b11 (both ways locked), a miss fills only an invalid way, way 0 first. If both ways are valid, alloc=0.
- R9: With cfgLock=2'b10 (way 0 locked), a miss fills way 0 only if way 0 is invalid. Otherwise it fills way 1 whatever the state of way 1.
- R10: invAll clears every valid flag at the next edge when cfgLock=2'b00 or cfgEnable=0, and is ignored otherwise. An accepted invalidate overrides a request in the same cycle. That request still reports its hit, but nothing is filled or marked.
- R11: A missing request with reqBlockMove=1 gives alloc=0 and leaves the set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Cache enable |
| cfgLock | input | 2 | Lock mode: 00 none, 01/11 both ways, 10 way 0 |
| invAll | input | 1 | Invalidate-all strobe |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | Request is a store |
| reqBlockMove | input | 1 | Request is a block-move load (no allocate) |
| reqShared | input | 1 | Fill data came from another cache |
| reqIndex | input | $clog2(SETS) | Set index |
| reqTag | input | TAG_W | Address tag |
| hit | output | 1 | Lookup hit |
| hitWay | output | 1 | Way that hit |
| hitModified | output | 1 | Dirty flag of the hit way |
| hitShared | output | 1 | Shared flag of the hit way |
| alloc | output | 1 | A fill takes place at this edge |
| allocWay | output | 1 | Way being filled |
| wbReq | output | 1 | Victim is dirty and must be written back |
| wbTag | output | TAG_W | Tag of the evicted victim |

## Verification
A corrupted valid flag or tag appears on the very next lookup of that set. It shows up as a hit where a miss is due, or as a fill into the wrong way. A stale dirty or shared flag shows up only when the line is hit again (hitModified, hitShared) or later evicted (wbReq, wbTag). A wrong replacement bit stays hidden until both ways of the set are valid and a miss arrives. The stimulus therefore keeps revisiting a handful of sets and tags, so that any such divergence from the reference model surfaces within a few requests.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  localparam logic [1:0] LOCK_NONE = 2'b00;
  localparam logic [1:0] LOCK_WAY0 = 2'b10;

  typedef struct packed {
    logic fillEn;
    logic fillWay;
    logic fillMod;
    logic fillShared;
    logic markEn;
    logic markWay;
    logic lruEn;
    logic lruNext;
    logic clearAll;
  } tag_strobe_t;
endpackage

// File: rtl/dtag_data.sv
module dtag_data
  import dtag_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IDX_W-1:0]      index,
  input  logic [TAG_W-1:0]      tagIn,
  input  tag_strobe_t           strb,
  output logic [1:0]            wayMatch,
  output logic [1:0]            wayValid,
  output logic [1:0]            wayMod,
  output logic [1:0]            wayShared,
  output logic [1:0][TAG_W-1:0] wayTag,
  output logic                  setLru
);
  logic [SETS-1:0] lruArr;

  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WAY = 1'(w);
    logic [SETS-1:0]  validArr;
    logic [SETS-1:0]  modArr;
    logic [SETS-1:0]  sharedArr;
    logic [TAG_W-1:0] tagArr [SETS];
    logic fillHere, markHere;

    assign fillHere = strb.fillEn && (strb.fillWay == WAY);
    assign markHere = strb.markEn && (strb.markWay == WAY);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              validArr <= '0;
      else if (strb.clearAll) validArr <= '0;
      else if (fillHere)      validArr[index] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fillHere) begin
        tagArr[index]    <= tagIn;
        modArr[index]    <= strb.fillMod;
        sharedArr[index] <= strb.fillShared;
      end else if (markHere) begin
        modArr[index]    <= 1'b1;
      end
    end

    assign wayValid[w]  = validArr[index];
    assign wayMod[w]    = modArr[index];
    assign wayShared[w] = sharedArr[index];
    assign wayTag[w]    = tagArr[index];
    assign wayMatch[w]  = validArr[index] && (tagArr[index] == tagIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lruArr <= '0;
    else if (strb.lruEn) lruArr[index] <= strb.lruNext;
  end

  assign setLru = lruArr[index];
endmodule

// File: rtl/dtag_ctrl.sv
module dtag_ctrl
  import dtag_pkg::*;
(
  input  logic        cfgEnable,
  input  logic [1:0]  cfgLock,
  input  logic        invAll,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqBlockMove,
  input  logic        reqShared,
  input  logic [1:0]  wayMatch,
  input  logic [1:0]  wayValid,
  input  logic [1:0]  wayMod,
  input  logic        setLru,
  output logic        hit,
  output logic        hitWay,
  output logic        alloc,
  output logic        allocWay,
  output logic        wbReq,
  output tag_strobe_t strb
);
  logic invOk, lookupOn, missOk, canFill, victim, allocOn, usedWay;

  assign invOk    = invAll && (cfgLock == LOCK_NONE || !cfgEnable);
  assign lookupOn = reqValid && cfgEnable;
  assign hit      = lookupOn && (|wayMatch);
  assign hitWay   = hit && wayMatch[1];
  assign missOk   = lookupOn && !(|wayMatch) && !reqBlockMove && !invOk;

  // Victim choice per lock mode; an invalid way always wins.
  always_comb begin
    canFill = 1'b1;
    victim  = 1'b0;
    if (cfgLock == LOCK_NONE) begin
      if (!wayValid[0])      victim = 1'b0;
      else if (!wayValid[1]) victim = 1'b1;
      else                   victim = setLru;
    end else if (cfgLock == LOCK_WAY0) begin
      victim = wayValid[0];
    end else begin
      canFill = !(&wayValid);
      victim  = wayValid[0];
    end
  end

  assign allocOn  = missOk && canFill;
  assign alloc    = allocOn;
  assign allocWay = allocOn && victim;
  assign wbReq    = allocOn && wayValid[victim] && wayMod[victim];
  assign usedWay  = hit ? hitWay : victim;

  always_comb begin
    strb            = '0;
    strb.clearAll   = invOk;
    strb.fillEn     = allocOn;
    strb.fillWay    = victim;
    strb.fillMod    = reqWrite;
    strb.fillShared = reqWrite && reqShared;
    strb.markEn     = hit && reqWrite && !invOk;
    strb.markWay    = hitWay;
    strb.lruEn      = (hit || allocOn) && !invOk;
    strb.lruNext    = !usedWay;
  end
endmodule

// File: rtl/dcache_tag_ctrl.sv
module dcache_tag_ctrl
  import dtag_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [1:0]       cfgLock,
  input  logic             invAll,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqBlockMove,
  input  logic             reqShared,
  input  logic [IDX_W-1:0] reqIndex,
  input  logic [TAG_W-1:0] reqTag,
  output logic             hit,
  output logic             hitWay,
  output logic             hitModified,
  output logic             hitShared,
  output logic             alloc,
  output logic             allocWay,
  output logic             wbReq,
  output logic [TAG_W-1:0] wbTag
);
  tag_strobe_t            strb;
  logic [1:0]             wayMatch, wayValid, wayMod, wayShared;
  logic [1:0][TAG_W-1:0]  wayTag;
  logic                   setLru;

  dtag_data #(.SETS(SETS), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rstN(rstN), .index(reqIndex), .tagIn(reqTag), .strb(strb),
    .wayMatch(wayMatch), .wayValid(wayValid), .wayMod(wayMod),
    .wayShared(wayShared), .wayTag(wayTag), .setLru(setLru)
  );

  dtag_ctrl u_ctrl (
    .cfgEnable(cfgEnable), .cfgLock(cfgLock), .invAll(invAll),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBlockMove(reqBlockMove),
    .reqShared(reqShared), .wayMatch(wayMatch), .wayValid(wayValid),
    .wayMod(wayMod), .setLru(setLru), .hit(hit), .hitWay(hitWay),
    .alloc(alloc), .allocWay(allocWay), .wbReq(wbReq), .strb(strb)
  );

  assign hitModified = hit && wayMod[hitWay];
  assign hitShared   = hit && wayShared[hitWay];
  assign wbTag       = wbReq ? wayTag[allocWay] : '0;
endmodule

// File: rtl/dtag_chk.sv
module dtag_chk #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 21
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgEnable,
  input logic [1:0]       cfgLock,
  input logic             invAll,
  input logic             reqValid,
  input logic             reqWrite,
  input logic             reqBlockMove,
  input logic             reqShared,
  input logic [IDX_W-1:0] reqIndex,
  input logic [TAG_W-1:0] reqTag,
  input logic             hit,
  input logic             hitWay,
  input logic             hitModified,
  input logic             hitShared,
  input logic             alloc,
  input logic             allocWay,
  input logic             wbReq,
  input logic [TAG_W-1:0] wbTag
);
  logic sameAgain;
  assign sameAgain = reqValid && cfgEnable && !invAll;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !hit && !alloc && !wbReq);
  p_hit_no_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> !alloc);
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !hit && !alloc);
  p_fill_then_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    alloc |=> (!(sameAgain && reqIndex == $past(reqIndex) && reqTag == $past(reqTag))
               || (hit && hitWay == $past(allocWay))));
  p_write_dirty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && reqWrite && !invAll) |=>
      (!(sameAgain && reqIndex == $past(reqIndex) && reqTag == $past(reqTag)) || hitModified));
  p_flags_need_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hitModified || hitShared) |-> hit);
  p_wb_with_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> alloc && wbTag != reqTag);
  p_shared_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alloc && reqWrite && reqShared) |=>
      (!(sameAgain && reqIndex == $past(reqIndex) && reqTag == $past(reqTag)) || hitShared));
  p_lock_all_no_wb_r8: assert property (@(posedge clk) disable iff (!rstN)
    (alloc && cfgLock[0]) |-> !wbReq);
  p_inv_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && (cfgLock == 2'b00 || !cfgEnable)) |=> !hit);
  p_blockmove_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqBlockMove) |-> !alloc);
endmodule

bind dcache_tag_ctrl dtag_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_dcache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_dcache_tag_ctrl;
  localparam int SETS  = 128;
  localparam int TAG_W = 21;
  localparam int IDX_W = 7;

  logic clk = 1'b0;
  logic rstN;
  logic cfgEnable, invAll, reqValid, reqWrite, reqBlockMove, reqShared;
  logic [1:0] cfgLock;
  logic [IDX_W-1:0] reqIndex;
  logic [TAG_W-1:0] reqTag;
  logic hit, hitWay, hitModified, hitShared, alloc, allocWay, wbReq;
  logic [TAG_W-1:0] wbTag;

  int checks = 0;
  int errors = 0;
  bit enB = 1'b1;
  logic [1:0] lockB = 2'b00;

  bit mV [SETS][2];
  bit mM [SETS][2];
  bit mS [SETS][2];
  int mT [SETS][2];
  bit mL [SETS];

  always #5 clk = ~clk;

  dcache_tag_ctrl #(.SETS(SETS), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgLock(cfgLock),
    .invAll(invAll), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBlockMove(reqBlockMove), .reqShared(reqShared), .reqIndex(reqIndex),
    .reqTag(reqTag), .hit(hit), .hitWay(hitWay), .hitModified(hitModified),
    .hitShared(hitShared), .alloc(alloc), .allocWay(allocWay), .wbReq(wbReq),
    .wbTag(wbTag)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // One request cycle: drive at negedge, compare combinational outputs, update model at the edge.
  task automatic step(input string tag, input bit v, input bit wr, input bit bm,
                      input bit sh, input bit inv, input int idx, input int tg);
    bit eHit, eWay, eAl, eAw, eWb, invEff, lockAll, lockW0;
    int eMod, eSh, eWt;
    @(negedge clk);
    cfgEnable = enB; cfgLock = lockB; invAll = inv;
    reqValid = v; reqWrite = wr; reqBlockMove = bm; reqShared = sh;
    reqIndex = IDX_W'(idx); reqTag = TAG_W'(tg);
    #1;
    lockAll = lockB[0];
    lockW0  = (lockB == 2'b10);
    invEff  = inv && (lockB == 2'b00 || !enB);
    eHit = 0; eWay = 0; eMod = 0; eSh = 0;
    if (v && enB)
      for (int w = 0; w < 2; w++)
        if (mV[idx][w] && mT[idx][w] == tg) begin eHit = 1; eWay = w[0]; end
    if (eHit) begin eMod = mM[idx][eWay]; eSh = mS[idx][eWay]; end
    eAl = 0; eAw = 0; eWb = 0; eWt = 0;
    if (v && enB && !eHit && !bm && !invEff) begin
      if (!mV[idx][0])      begin eAl = 1; eAw = 0; end
      else if (lockW0)      begin eAl = 1; eAw = 1; end
      else if (!mV[idx][1]) begin eAl = 1; eAw = 1; end
      else if (!lockAll)    begin eAl = 1; eAw = mL[idx]; end
    end
    if (eAl && mV[idx][eAw] && mM[idx][eAw]) begin eWb = 1; eWt = mT[idx][eAw]; end
    chk(tag, "hit", int'(hit), int'(eHit));
    chk(tag, "hitWay", int'(hitWay), int'(eWay));
    chk(tag, "hitModified", int'(hitModified), eMod);
    chk(tag, "hitShared", int'(hitShared), eSh);
    chk(tag, "alloc", int'(alloc), int'(eAl));
    chk(tag, "allocWay", int'(allocWay), int'(eAw));
    chk(tag, "wbReq", int'(wbReq), int'(eWb));
    chk(tag, "wbTag", int'(wbTag), eWt);
    @(posedge clk);
    if (invEff) begin
      for (int s = 0; s < SETS; s++) begin mV[s][0] = 0; mV[s][1] = 0; end
    end else begin
      if (eHit) begin
        if (wr) mM[idx][eWay] = 1;
        mL[idx] = !eWay;
      end
      if (eAl) begin
        mV[idx][eAw] = 1; mT[idx][eAw] = tg;
        mM[idx][eAw] = wr; mS[idx][eAw] = wr && sh;
        mL[idx] = !eAw;
      end
    end
  endtask

  task automatic rd(input string tag, input int idx, input int tg);
    step(tag, 1, 0, 0, 0, 0, idx, tg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    bit rv, rw, rb, rs, ri;
    int ridx, rtg;
    for (int s = 0; s < SETS; s++) begin
      mV[s][0] = 0; mV[s][1] = 0; mM[s][0] = 0; mM[s][1] = 0;
      mS[s][0] = 0; mS[s][1] = 0; mT[s][0] = 0; mT[s][1] = 0; mL[s] = 0;
    end
    rstN = 0; cfgEnable = 1; cfgLock = 2'b00; invAll = 0; reqValid = 0;
    reqWrite = 0; reqBlockMove = 0; reqShared = 0; reqIndex = '0; reqTag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: idle outputs, then first lookup misses and fills way 0
    step("R1", 0, 0, 0, 0, 0, 3, 11);
    rd("R1", 3, 11);
    // R2: same address now hits way 0
    rd("R2", 3, 11);
    // R4: invalid way 1 preferred, then replacement bit decides
    rd("R4", 3, 12);
    rd("R4", 3, 11);
    rd("R4", 3, 13);
    rd("R4", 3, 13);
    // R5: write hit marks dirty, visible on next hit
    step("R5", 1, 1, 0, 0, 0, 3, 11);
    rd("R5", 3, 11);
    // R6: evict the dirty way
    rd("R6", 3, 13);
    rd("R6", 3, 14);
    // R7: shared fill on a write, plain fill on a write without sharing
    step("R7", 1, 1, 0, 1, 0, 9, 21);
    rd("R7", 9, 21);
    step("R7", 1, 1, 0, 0, 0, 10, 22);
    rd("R7", 10, 22);
    // R3: disabled lookups neither hit nor fill
    enB = 0;
    rd("R3", 9, 21);
    step("R3", 1, 1, 0, 0, 0, 9, 30);
    enB = 1;
    rd("R3", 9, 21);
    rd("R3", 9, 30);
    // R8: both ways locked
    rd("R8", 20, 40); rd("R8", 20, 41);
    lockB = 2'b01;
    rd("R8", 20, 42);
    rd("R8", 20, 42);
    // R10: invalidate refused while locked and enabled
    step("R10", 0, 0, 0, 0, 1, 20, 40);
    rd("R10", 20, 40);
    // R10: accepted when disabled
    enB = 0;
    step("R10", 0, 0, 0, 0, 1, 20, 40);
    enB = 1; lockB = 2'b11;
    rd("R10", 20, 40);
    rd("R8", 20, 43);
    // R9: way 0 locked
    lockB = 2'b00;
    rd("R9", 30, 50); rd("R9", 30, 51);
    step("R9", 1, 1, 0, 0, 0, 30, 51);
    lockB = 2'b10;
    rd("R9", 30, 52);
    rd("R9", 30, 53);
    rd("R9", 30, 50);
    // R11: block-move miss does not allocate
    lockB = 2'b00;
    step("R11", 1, 0, 1, 0, 0, 40, 60);
    rd("R11", 40, 60);
    // R10: accepted invalidate overrides a simultaneous request
    rd("R10", 41, 61);
    step("R10", 1, 1, 0, 0, 1, 41, 61);
    rd("R10", 41, 61);
    // R1: highest index behaves like any other set
    rd("R1", SETS - 1, (1 << TAG_W) - 1);
    rd("R2", SETS - 1, (1 << TAG_W) - 1);

    // Random mix over few sets and tags so that hits, evictions and locks interact
    r = $urandom(32'd2024);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 99) < 3) lockB = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 4) enB = !enB;
      if (!enB && $urandom_range(0, 99) < 50) enB = 1;
      rv = ($urandom_range(0, 99) < 90);
      rw = ($urandom_range(0, 99) < 40);
      rb = ($urandom_range(0, 99) < 10);
      rs = ($urandom_range(0, 99) < 50);
      ri = ($urandom_range(0, 999) < 15);
      ridx = ($urandom_range(0, 19) == 0) ? SETS - 1 : int'($urandom_range(0, 3));
      rtg  = ($urandom_range(0, 9) == 0) ? (1 << TAG_W) - 1 : int'($urandom_range(1, 5));
      step("R4", rv, rw, rb, rs, ri, ridx, rtg);
    end

    @(negedge clk);
    reqValid = 0; invAll = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule